// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects interrupt events from six sources (two external inputs, three timer overflows and one serial-port event) and decides which one the CPU should service next. Software configures it through a small write/read port that holds two 8-bit registers: an enable register and a priority register. A source is a candidate only when the global gate bit and its own enable bit are both set. Each candidate sits at one of two levels, high or low. Within a level, a fixed polling order settles ties.

The controller keeps one in-service flag per level, which allows a single level of nesting. A high-level request may interrupt a low-level handler. While a high-level handler runs, nothing is accepted. When the CPU acknowledges the offered request, the block latches that level as in service and drops the source's pending flag. The serial source is the exception: software clears its flag. A return pulse closes the innermost active handler.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A pending source is offered only if enable bit 7 (global gate) and the source's own enable bit are both 1. Clearing either bit withdraws the offer.
- R2: Enable register (cfg_sel=0) bits: 7 gate, 6 unused (reads 0), 5 timer2, 4 serial, 3 timer1, 2 external1, 1 timer0, 0 external0.
- R3: Priority register (cfg_sel=1) bits: 7..6 unused (read 0), 5 timer2, 4 serial, 3 timer1, 2 external1, 1 timer0, 0 external0. A 1 means high level.
- R4: After reset, both registers read 0x00 and irq_req is 0.
- R5: Within one level, the lowest index wins. The index order is external0=0, timer0=1, external1=2, timer1=3, serial=4, timer2=5, and irq_idx reports this index.
- R6: A high-level request is offered while a low-level handler is in service.
- R7: A low-level request is not offered while the low-level in-service flag is set.
- R8: irq_ack while irq_req is 1 sets the in-service flag of the offered level. irq_ret clears the high flag if it is set, and otherwise the low flag.
- R9: While the high-level flag is set, irq_req stays 0 whatever the pending sources and their levels.
- R10: Acknowledge clears the offered source's pending flag, except for serial (index 4). The serial flag is cleared only by ser_flag_clr.
- R11: An event pulse on src_evt becomes visible on irq_req after one clock edge. A pending flag survives while it is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | 6 | One-cycle event per source, bit = source index |
| ser_flag_clr | input | 1 | Software clear of the serial pending flag |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects enable register, 1 selects priority register |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| irq_req | output | 1 | A request is offered to the CPU |
| irq_idx | output | 3 | Index of the offered source |
| irq_ack | input | 1 | CPU accepts the offered request |
| irq_ret | input | 1 | Return-from-handler pulse |

## Verification
The hardest state to reach is a low-level handler preempted by a high-level one, with further requests arriving while both flags are set. The return pulses then have to unwind the flags in the right order. The stimulus acknowledges a low-level source and raises a high-level source to preempt it. It then posts both a high-level and a low-level source while the high handler runs. Two returns follow, and the bench watches which source becomes visible after each one. Repeated offers of the serial source after its acknowledge also need a dedicated sequence, because only the explicit clear makes the next source appear.

// File: rtl/irq_pkg.sv
// Package: shared constants, types and the polling-order picker for the
// interrupt controller. Assumes source index equals register bit position.
package irq_pkg;
    localparam int NSRC     = 6;
    localparam int IDXW     = 3;
    localparam int REGW     = 8;
    localparam int GATE_BIT = REGW - 1;
    localparam int SER_IDX  = 4;
    localparam int PADW     = REGW - NSRC - 1;

    typedef struct packed {
        logic            hit;
        logic [IDXW-1:0] idx;
    } pick_t;

    // Lowest set index wins (fixed polling order).
    function automatic pick_t pick_first(input logic [NSRC-1:0] v);
        pick_t p;
        p.hit = 1'b0;
        p.idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = IDXW'(i);
            end
        end
        return p;
    endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
// Module: enable and priority registers with combinational read-back.
// Assumes a single write strobe; unimplemented bits read as zero.
module irq_cfg_regs
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic                sel,
    input  logic [REGW-1:0]     wdata,
    output logic [REGW-1:0]     rdata,
    output logic                gate,
    output logic [NSRC-1:0]     en,
    output logic [NSRC-1:0]     prio
);
    // Register update on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate <= 1'b0;
            en   <= '0;
            prio <= '0;
        end else if (we) begin
            if (sel) begin
                prio <= wdata[NSRC-1:0];
            end else begin
                gate <= wdata[GATE_BIT];
                en   <= wdata[NSRC-1:0];
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        if (sel) rdata = {{(REGW-NSRC){1'b0}}, prio};
        else     rdata = {gate, {PADW{1'b0}}, en};
    end
endmodule

// File: rtl/irq_pend_bank.sv
// Module: one pending flag per source. A new event wins over a clear in
// the same cycle. The serial flag ignores acknowledge clears.
module irq_pend_bank
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_v,
    input  logic [NSRC-1:0] ack_clr,
    input  logic            ser_clr,
    output logic [NSRC-1:0] pend
);
    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        logic clr_g;
        if (g == SER_IDX) begin : g_ser
            assign clr_g = ser_clr;
        end else begin : g_std
            assign clr_g = ack_clr[g];
        end
        // Hold, set or clear one pending flag.
        always_ff @(posedge clk) begin
            if (!rst_n) pend[g] <= 1'b0;
            else        pend[g] <= set_v[g] | (pend[g] & ~clr_g);
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
// Module: masks pending flags, splits them by level and picks a winner.
// Purely combinational; assumes in-service flags come from irq_inservice.
module irq_arbiter
    import irq_pkg::*;
(
    input  logic            gate,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] prio,
    input  logic [NSRC-1:0] pend,
    input  logic            ins_hi,
    input  logic            ins_lo,
    output logic            req,
    output logic [IDXW-1:0] idx,
    output logic            lvl_hi
);
    logic [NSRC-1:0] elig;
    pick_t           hi_p, lo_p;

    // Per-level candidate selection.
    always_comb begin
        elig = pend & en & {NSRC{gate}};
        hi_p = pick_first(elig & prio);
        lo_p = pick_first(elig & ~prio);
    end

    // Level resolution against the in-service state.
    always_comb begin
        req    = 1'b0;
        idx    = '0;
        lvl_hi = 1'b0;
        if (!ins_hi) begin
            if (hi_p.hit) begin
                req    = 1'b1;
                idx    = hi_p.idx;
                lvl_hi = 1'b1;
            end else if (!ins_lo && lo_p.hit) begin
                req = 1'b1;
                idx = lo_p.idx;
            end
        end
    end
endmodule

// File: rtl/irq_inservice.sv
// Module: one in-service flag per level. A return clears the innermost
// level; an acknowledge in the same cycle still sets its level.
module irq_inservice (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic take_hi,
    input  logic ret,
    output logic ins_hi,
    output logic ins_lo
);
    logic hi_d, lo_d;

    // Next-state of both flags.
    always_comb begin
        hi_d = ins_hi;
        lo_d = ins_lo;
        if (ret) begin
            if (ins_hi) hi_d = 1'b0;
            else        lo_d = 1'b0;
        end
        if (take) begin
            if (take_hi) hi_d = 1'b1;
            else         lo_d = 1'b1;
        end
    end

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_hi <= 1'b0;
            ins_lo <= 1'b0;
        end else begin
            ins_hi <= hi_d;
            ins_lo <= lo_d;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: top of the two-level interrupt controller. Wires registers,
// pending bank, arbiter and in-service tracker. Assumes irq_ack is only
// meaningful while irq_req is high; otherwise it is ignored.
module irq_prio_ctrl
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_evt,
    input  logic            ser_flag_clr,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [REGW-1:0] cfg_wdata,
    output logic [REGW-1:0] cfg_rdata,
    output logic            irq_req,
    output logic [IDXW-1:0] irq_idx,
    input  logic            irq_ack,
    input  logic            irq_ret
);
    logic            gate;
    logic [NSRC-1:0] en, prio, pend, ack_clr;
    logic            ins_hi, ins_lo, lvl_hi, take;

    irq_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .rdata(cfg_rdata),
        .gate(gate), .en(en), .prio(prio)
    );

    // Acknowledge decode into a one-hot clear.
    always_comb begin
        take    = irq_ack & irq_req;
        ack_clr = '0;
        if (take) ack_clr[irq_idx] = 1'b1;
    end

    irq_pend_bank u_pend (
        .clk(clk), .rst_n(rst_n), .set_v(src_evt), .ack_clr(ack_clr),
        .ser_clr(ser_flag_clr), .pend(pend)
    );

    irq_arbiter u_arb (
        .gate(gate), .en(en), .prio(prio), .pend(pend),
        .ins_hi(ins_hi), .ins_lo(ins_lo),
        .req(irq_req), .idx(irq_idx), .lvl_hi(lvl_hi)
    );

    irq_inservice u_ins (
        .clk(clk), .rst_n(rst_n), .take(take), .take_hi(lvl_hi),
        .ret(irq_ret), .ins_hi(ins_hi), .ins_lo(ins_lo)
    );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
// Module: property checker for irq_prio_ctrl, attached by bind.
module irq_prio_ctrl_chk
    import irq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            gate,
    input logic [NSRC-1:0] en,
    input logic [NSRC-1:0] prio,
    input logic            ins_hi,
    input logic            ins_lo,
    input logic            irq_req,
    input logic [IDXW-1:0] irq_idx,
    input logic            irq_ack,
    input logic            irq_ret
);
    AST_OFFER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (gate && en[irq_idx]));                          // R1
    AST_HI_SEALED: assert property (@(posedge clk) disable iff (!rst_n)
        ins_hi |-> !irq_req);                                         // R9
    AST_LO_NEEDS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && ins_lo) |-> prio[irq_idx]);                       // R7
    AST_ACK_HI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && prio[irq_idx]) |=> ins_hi);            // R8
    AST_ACK_LO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !prio[irq_idx]) |=> ins_lo);           // R8
    AST_RET_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && ins_hi && !irq_ack) |=> (!ins_hi && ins_lo == $past(ins_lo))); // R8
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .gate(gate), .en(en), .prio(prio),
    .ins_hi(ins_hi), .ins_lo(ins_lo), .irq_req(irq_req),
    .irq_idx(irq_idx), .irq_ack(irq_ack), .irq_ret(irq_ret)
);

// File: tb/irq_prio_ctrl_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module irq_prio_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] src_evt = '0;
    logic       ser_flag_clr = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       irq_req;
    logic [2:0] irq_idx;
    logic       irq_ack = 1'b0;
    logic       irq_ret = 1'b0;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
        .ser_flag_clr(ser_flag_clr), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq_req(irq_req), .irq_idx(irq_idx),
        .irq_ack(irq_ack), .irq_ret(irq_ret)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        src_evt = '0; ser_flag_clr = 0; cfg_we = 0; irq_ack = 0; irq_ret = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        @(negedge clk);
        cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    task automatic fire(input logic [5:0] m);
        @(negedge clk);
        src_evt = m;
        @(negedge clk);
        src_evt = '0;
    endtask

    task automatic take(input string tag, input int exp_idx);
        @(negedge clk);
        chk({tag, " req"}, int'(irq_req), 1);
        chk({tag, " idx"}, int'(irq_idx), exp_idx);
        irq_ack = 1;
        @(negedge clk);
        irq_ack = 0;
    endtask

    task automatic ret();
        @(negedge clk);
        irq_ret = 1;
        @(negedge clk);
        irq_ret = 0;
    endtask

    task automatic ser_clear();
        @(negedge clk);
        ser_flag_clr = 1;
        @(negedge clk);
        ser_flag_clr = 0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        @(negedge clk);
        chk("R4 irq_req", int'(irq_req), 0);
        rd(1'b0, d); chk("R4 enable", int'(d), 8'h00);
        rd(1'b1, d); chk("R4 priority", int'(d), 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        do_reset();
        wr(1'b0, 8'hFF); rd(1'b0, d); chk("R2 enable FF", int'(d), 8'hBF);
        wr(1'b0, 8'h55); rd(1'b0, d); chk("R2 enable 55", int'(d), 8'h15);
        wr(1'b1, 8'hFF); rd(1'b1, d); chk("R3 prio FF", int'(d), 8'h3F);
        wr(1'b1, 8'h96); rd(1'b1, d); chk("R3 prio 96", int'(d), 8'h16);
    endtask

    task automatic t_gate();
        do_reset();
        wr(1'b0, 8'h01);
        fire(6'h01);
        chk("R1 no gate", int'(irq_req), 0);
        wr(1'b0, 8'h81);
        chk("R1 R11 gated on req", int'(irq_req), 1);
        chk("R1 gated on idx", int'(irq_idx), 0);
        wr(1'b0, 8'h80);
        chk("R1 own bit off", int'(irq_req), 0);
        wr(1'b0, 8'h81);
        chk("R11 pending kept", int'(irq_req), 1);
        do_reset();
        wr(1'b0, 8'hBF);
        @(negedge clk);
        src_evt = 6'h08;
        @(negedge clk);
        src_evt = '0;
        chk("R11 one edge", int'(irq_req), 1);
    endtask

    task automatic t_poll();
        do_reset();
        wr(1'b0, 8'hBF);
        fire(6'h3F);
        for (int k = 0; k < 4; k++) begin
            take("R5 low order", k);
            chk("R7 low blocked", int'(irq_req), 0);
            ret();
        end
        take("R5 serial", 4);
        ret();
        chk("R10 serial again req", int'(irq_req), 1);
        chk("R10 serial again idx", int'(irq_idx), 4);
        ser_clear();
        take("R10 after clear", 5);
        ret();
        chk("R10 all cleared", int'(irq_req), 0);
    endtask

    task automatic t_preempt();
        do_reset();
        wr(1'b0, 8'hBF);
        wr(1'b1, 8'h22);
        fire(6'h01);
        take("R8 low take", 0);
        fire(6'h20);
        take("R6 preempt", 5);
        fire(6'h02);
        chk("R9 hi sealed", int'(irq_req), 0);
        ret();
        take("R8 after hi ret", 1);
        ret();
        fire(6'h04);
        chk("R8 low still active", int'(irq_req), 0);
        ret();
        take("R8 low ret", 2);
        ret();
        chk("R8 idle", int'(irq_req), 0);
    endtask

    task automatic t_hi_order();
        do_reset();
        wr(1'b0, 8'hBF);
        wr(1'b1, 8'h3F);
        fire(6'h0C);
        take("R5 high order", 2);
        chk("R9 high blocks high", int'(irq_req), 0);
        ret();
        take("R5 high next", 3);
        ret();
        chk("R5 high done", int'(irq_req), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_regs();
        t_gate();
        t_poll();
        t_preempt();
        t_hi_order();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule